// File: doc/BRIEF.md
# MAC Forwarding Table

A station-address table for a small switch. It holds a parameterised number of 68-bit entries that software reaches only indirectly: three 32-bit data-word registers stage an entry, and a table-control register either loads those words from a chosen index or commits them to it. A global control register enables the engine, stores a VLAN-aware mode flag and starts a self-clearing wipe of the whole table. Each switch port has its own state register, and only ports in the forwarding state may appear in a result.

A lookup request carries a destination MAC and the ingress port. The engine walks the table one entry per clock, lowest index first, and stops at the first address entry whose MAC matches. A multicast entry supplies a port mask, a unicast entry supplies one egress port, and a blocked unicast entry discards the frame. A miss floods to every forwarding port. The ingress port is always removed from the result.

Requests use a valid/ready handshake: `lk_ready` is high only when the engine is enabled, not clearing and holding no request, and a request is taken in a cycle where both `lk_valid` and `lk_ready` are high. The result is offered on `res_valid`; while `res_ready` is low, the result stays unchanged and no new request is accepted. The register port has no handshake: a write takes effect at the clock edge, and `reg_rdata` follows `reg_addr` with no clock in between.

Top module: `mac_fwd_table`

## Requirements
- R1: After reset, every table entry is free, the global control register and both port-state registers read 0, and `lk_ready` is low.
- R2: The data words map to entry bits as follows: word at 0x10 holds bits 67:64 in its low 4 bits (upper bits read 0), word at 0x14 holds bits 63:32, and word at 0x18 holds bits 31:0. Writing the index to 0x04 with bit 31 set stores the three words into that entry. With bit 31 clear, the write loads that entry into the three words, readable in the next cycle.
- R3: Entry bits 61:60 give the type: 0 free, 1 address, 2 VLAN, 3 VLAN+address. Only types 1 and 3 can match a lookup, and they are compared against MAC bits 47:0.
- R4: On a hit whose entry bit 40 is set (multicast), the result is entry bits 67:66 used as a port mask (bit 66 is port 0), ANDed with the forwarding ports and with the ingress port removed.
- R5: On a unicast hit, bits 67:66 give the egress port number and the result has only that port's bit, gated by forwarding state and ingress removal. When bit 65 (blocked) is set, the result is empty and `res_hit` is still 1.
- R6: On a miss, the result is every forwarding port except the ingress port, with `res_hit` 0.
- R7: The state register for port p sits at byte address 0x20+4p, and its low 2 bits hold the state (0 disabled, 1 blocked, 2 learning, 3 forwarding). Only state 3 lets a port appear in a result.
- R8: The scan starts at index 0, one entry per clock. A hit at index k gives `res_valid` k+1 clock edges after the accepting edge, and a miss gives it ENTRIES edges after. When two entries match, the lower index wins.
- R9: Writing bit 30 of the global control register (0x00) clears one entry per clock. Bit 30 reads 1 until it clears itself ENTRIES edges after the write, at which point every entry is free. `lk_ready` is low while the clear runs.
- R10: While `res_valid` is high and `res_ready` is low, `res_mask` and `res_hit` hold their values and `lk_ready` stays low.
- R11: Bit 31 of the global control register enables the engine. While it is 0, `lk_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Engine can accept a lookup |
| lk_dmac | input | 48 | Destination MAC, first transmitted byte in bits 47:40 |
| lk_port | input | 1 | Ingress port number |
| res_valid | output | 1 | Lookup result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_mask | output | 2 | Egress port mask, bit p is port p |
| res_hit | output | 1 | An address entry matched |

## Verification
Every result has a fixed latency. `res_valid` rises k+1 edges after the accepting edge for a hit at index k, and ENTRIES edges after it for a miss. A table read is visible one edge after the index write, and the clear bit falls exactly ENTRIES edges after it is set. The bench drives on falling edges and counts whole clock edges from the accepting edge to the first falling edge where `res_valid` is seen, then compares that count with the expected value. Register and clear checks are sampled at the falling edge that follows the edge on which the state must have changed, so each comparison falls in the cycle the requirement names.

// File: rtl/mft_pkg.sv
package mft_pkg;
  localparam int ENT_W  = 68;
  localparam int MAC_W  = 48;
  localparam int NPORT  = 2;
  localparam int PORT_W = 1;

  typedef enum logic [1:0] {
    ET_FREE  = 2'd0,
    ET_ADDR  = 2'd1,
    ET_VLAN  = 2'd2,
    ET_VADDR = 2'd3
  } ent_type_e;

  localparam logic [1:0] PS_FWD = 2'd3;

  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_TBL   = 8'h04;
  localparam logic [7:0] A_W0    = 8'h10;
  localparam logic [7:0] A_W1    = 8'h14;
  localparam logic [7:0] A_W2    = 8'h18;
  localparam logic [7:0] A_PORT0 = 8'h20;
endpackage

// File: rtl/mft_regs.sv
module mft_regs
  import mft_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [7:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [IW-1:0]    scan_idx,
  output logic [ENT_W-1:0] scan_entry,
  output logic [NPORT-1:0] fwd_mask,
  output logic             eng_en,
  output logic             clr_busy
);
  logic [ENT_W-1:0] tbl [ENTRIES];
  logic             en_q, clr_q, vlan_q;
  logic [1:0]       pst [NPORT];
  logic [3:0]       w0;
  logic [31:0]      w1, w2;
  logic [IW-1:0]    clr_idx;
  logic [IW-1:0]    widx;

  assign widx = wdata[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      clr_q   <= 1'b0;
      vlan_q  <= 1'b0;
      w0      <= '0;
      w1      <= '0;
      w2      <= '0;
      clr_idx <= '0;
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
      for (int p = 0; p < NPORT; p++) pst[p] <= 2'd0;
    end else begin
      if (clr_q) begin
        tbl[clr_idx] <= '0;
        if (clr_idx == IW'(ENTRIES - 1)) begin
          clr_q   <= 1'b0;
          clr_idx <= '0;
        end else begin
          clr_idx <= clr_idx + 1'b1;
        end
      end
      if (wr) begin
        unique case (addr)
          A_CTRL: begin
            en_q   <= wdata[31];
            vlan_q <= wdata[2];
            if (wdata[30]) clr_q <= 1'b1;
          end
          A_TBL: if (!clr_q) begin
            if (wdata[31]) tbl[widx] <= {w0, w1, w2};
            else begin
              w0 <= tbl[widx][67:64];
              w1 <= tbl[widx][63:32];
              w2 <= tbl[widx][31:0];
            end
          end
          A_W0: w0 <= wdata[3:0];
          A_W1: w1 <= wdata;
          A_W2: w2 <= wdata;
          default: begin
            for (int p = 0; p < NPORT; p++)
              if (addr == A_PORT0 + 8'(4 * p)) pst[p] <= wdata[1:0];
          end
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL: rdata = {en_q, clr_q, 27'd0, vlan_q, 2'd0};
      A_W0:   rdata = {28'd0, w0};
      A_W1:   rdata = w1;
      A_W2:   rdata = w2;
      default: begin
        for (int p = 0; p < NPORT; p++)
          if (addr == A_PORT0 + 8'(4 * p)) rdata = {30'd0, pst[p]};
      end
    endcase
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) fwd_mask[p] = (pst[p] == PS_FWD);
  end

  assign scan_entry = tbl[scan_idx];
  assign eng_en     = en_q;
  assign clr_busy   = clr_q;

  logic all_free;
  always_comb begin
    all_free = 1'b1;
    for (int i = 0; i < ENTRIES; i++)
      if (tbl[i][61:60] != ET_FREE) all_free = 1'b0;
  end

  // R9
  clr_done_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clr_q) |-> all_free);
  // R9
  clr_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && clr_idx != IW'(ENTRIES - 1)) |=> clr_q);
endmodule

// File: rtl/mft_fwd.sv
module mft_fwd
  import mft_pkg::*;
(
  input  logic              hit,
  input  logic              mcast,
  input  logic              blocked,
  input  logic [1:0]        pfield,
  input  logic [NPORT-1:0]  fwd_mask,
  input  logic [PORT_W-1:0] ingress,
  output logic [NPORT-1:0]  mask
);
  logic [NPORT-1:0] raw, ing_oh;

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      ing_oh[p] = (ingress == PORT_W'(p));
      if (!hit)         raw[p] = 1'b1;
      else if (mcast)   raw[p] = pfield[p];
      else if (blocked) raw[p] = 1'b0;
      else              raw[p] = (pfield == 2'(p));
    end
    mask = raw & fwd_mask & ~ing_oh;
  end
endmodule

// File: rtl/mft_search.sv
module mft_search
  import mft_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eng_en,
  input  logic              clr_busy,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [MAC_W-1:0]  lk_dmac,
  input  logic [PORT_W-1:0] lk_port,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [NPORT-1:0]  res_mask,
  output logic              res_hit,
  output logic [IW-1:0]     scan_idx,
  input  logic [ENT_W-1:0]  scan_entry,
  input  logic [NPORT-1:0]  fwd_mask
);
  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_RESP} st_e;
  st_e               st;
  logic [MAC_W-1:0]  dmac_q;
  logic [PORT_W-1:0] port_q;
  logic [IW-1:0]     idx;
  logic [NPORT-1:0]  mask_q, fmask;
  logic              hit_q, match, last;
  ent_type_e         ety;
  logic              unused_bits;

  assign unused_bits = ^scan_entry[64:62] ^ ^scan_entry[59:48];
  assign ety   = ent_type_e'(scan_entry[61:60]);
  assign match = (ety == ET_ADDR || ety == ET_VADDR) && scan_entry[47:0] == dmac_q;
  assign last  = (idx == IW'(ENTRIES - 1));

  mft_fwd u_fwd (
    .hit(match), .mcast(scan_entry[40]), .blocked(scan_entry[65]),
    .pfield(scan_entry[67:66]), .fwd_mask(fwd_mask), .ingress(port_q),
    .mask(fmask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      dmac_q <= '0;
      port_q <= '0;
      idx    <= '0;
      mask_q <= '0;
      hit_q  <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (lk_valid && lk_ready) begin
          dmac_q <= lk_dmac;
          port_q <= lk_port;
          idx    <= '0;
          st     <= S_SCAN;
        end
        S_SCAN: if (match || last) begin
          mask_q <= fmask;
          hit_q  <= match;
          st     <= S_RESP;
        end else begin
          idx <= idx + 1'b1;
        end
        default: if (res_ready) st <= S_IDLE;
      endcase
    end
  end

  assign lk_ready  = (st == S_IDLE) && eng_en && !clr_busy;
  assign res_valid = (st == S_RESP);
  assign res_mask  = mask_q;
  assign res_hit   = hit_q;
  assign scan_idx  = idx;

  // R10
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_mask) && $stable(res_hit)));
  // R10
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !lk_ready);
  // R7
  only_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> ((res_mask & ~$past(fwd_mask)) == '0));
  // R6
  no_ingress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !res_mask[port_q]);
  // R11
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_en |-> !lk_ready);
  // R9
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |-> !lk_ready);
endmodule

// File: rtl/mac_fwd_table.sv
module mac_fwd_table
  import mft_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        lk_valid,
  output logic        lk_ready,
  input  logic [47:0] lk_dmac,
  input  logic        lk_port,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [1:0]  res_mask,
  output logic        res_hit
);
  localparam int IW = $clog2(ENTRIES);

  logic [IW-1:0]    scan_idx;
  logic [ENT_W-1:0] scan_entry;
  logic [NPORT-1:0] fwd_mask;
  logic             eng_en, clr_busy;

  mft_regs #(.ENTRIES(ENTRIES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .scan_idx(scan_idx), .scan_entry(scan_entry),
    .fwd_mask(fwd_mask), .eng_en(eng_en), .clr_busy(clr_busy)
  );

  mft_search #(.ENTRIES(ENTRIES)) u_search (
    .clk(clk), .rst_n(rst_n), .eng_en(eng_en), .clr_busy(clr_busy),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_dmac(lk_dmac),
    .lk_port(lk_port), .res_valid(res_valid), .res_ready(res_ready),
    .res_mask(res_mask), .res_hit(res_hit), .scan_idx(scan_idx),
    .scan_entry(scan_entry), .fwd_mask(fwd_mask)
  );
endmodule

// File: tb/test_mac_fwd_table.sv
`timescale 1ns/1ps
module test_mac_fwd_table;
  localparam int N = 16;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        lk_valid = 1'b0, lk_ready, lk_port = 1'b0;
  logic [47:0] lk_dmac = '0;
  logic        res_valid, res_ready = 1'b0, res_hit;
  logic [1:0]  res_mask;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mac_fwd_table #(.ENTRIES(N)) i_mac_fwd_table (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_ready(lk_ready), .lk_dmac(lk_dmac), .lk_port(lk_port),
    .res_valid(res_valid), .res_ready(res_ready), .res_mask(res_mask),
    .res_hit(res_hit)
  );

  localparam logic [47:0] MAC_A = 48'h02_11_22_33_44_55;
  localparam logic [47:0] MAC_B = 48'h02_66_77_88_99_AA;
  localparam logic [47:0] MAC_C = 48'h02_C0_C1_C2_C3_C4;
  localparam logic [47:0] MAC_D = 48'h02_D0_D1_D2_D3_D4;
  localparam logic [47:0] MAC_M = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] MAC_X = 48'h0A_0B_0C_0D_0E_0F;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  function automatic logic [67:0] ent(input logic [1:0] ty, input logic blk,
                                      input logic [1:0] pf, input logic [47:0] mac);
    return {pf, blk, 1'b0, 2'b00, ty, 12'h000, mac};
  endfunction

  task automatic put(input int idx, input logic [67:0] e);
    wr(8'h10, {28'd0, e[67:64]});
    wr(8'h14, e[63:32]);
    wr(8'h18, e[31:0]);
    wr(8'h04, 32'h8000_0000 | 32'(idx));
  endtask

  task automatic lookup(input string req, input logic [47:0] mac, input logic port,
                        input logic [1:0] exp_mask, input logic exp_hit, input int exp_lat);
    int cnt = 0;
    @(negedge clk);
    while (!lk_ready && cnt < 100) begin @(negedge clk); cnt++; end
    lk_valid = 1'b1; lk_dmac = mac; lk_port = port;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    cnt = 0;
    while (!res_valid && cnt < 200) begin @(negedge clk); cnt++; end
    chk({req, " latency"}, cnt, exp_lat);
    chk({req, " mask"}, {30'd0, res_mask}, {30'd0, exp_mask});
    chk({req, " hit"}, {31'd0, res_hit}, {31'd0, exp_hit});
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, d); chk("R1 ctrl", d, 0);
    rd(8'h20, d); chk("R1 port0", d, 0);
    rd(8'h24, d); chk("R1 port1", d, 0);
    chk("R1 lk_ready", {31'd0, lk_ready}, 0);
    wr(8'h04, 32'd9);
    rd(8'h14, d); chk("R1 entry9 hi", d, 0);
    rd(8'h18, d); chk("R1 entry9 lo", d, 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(8'h00, 32'h8000_0000);
    chk("R11 ready after enable", {31'd0, lk_ready}, 1);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h24, 32'h0000_0003);
    rd(8'h20, d); chk("R7 port0 state", d, 3);
    rd(8'h24, d); chk("R7 port1 state", d, 3);
  endtask

  task automatic t_words();
    logic [31:0] d;
    wr(8'h10, 32'hFFFF_FFF6);
    wr(8'h14, 32'h3234_5678);
    wr(8'h18, 32'h9ABC_DEF0);
    wr(8'h04, 32'h8000_0005);
    wr(8'h10, 0); wr(8'h14, 0); wr(8'h18, 0);
    wr(8'h04, 32'h0000_0005);
    rd(8'h10, d); chk("R2 word0", d, 32'h6);
    rd(8'h14, d); chk("R2 word1", d, 32'h3234_5678);
    rd(8'h18, d); chk("R2 word2", d, 32'h9ABC_DEF0);
  endtask

  task automatic t_miss();
    lookup("R6 miss from port0", MAC_X, 1'b0, 2'b10, 1'b0, N);
    lookup("R6 miss from port1", MAC_X, 1'b1, 2'b01, 1'b0, N);
  endtask

  task automatic t_unicast();
    put(3, ent(2'd1, 1'b0, 2'd1, MAC_A));
    put(4, ent(2'd1, 1'b1, 2'd0, MAC_B));
    lookup("R5 unicast to port1", MAC_A, 1'b0, 2'b10, 1'b1, 4);
    lookup("R5 unicast to ingress", MAC_A, 1'b1, 2'b00, 1'b1, 4);
    lookup("R5 blocked drop", MAC_B, 1'b1, 2'b00, 1'b1, 5);
  endtask

  task automatic t_mcast();
    put(6, ent(2'd1, 1'b0, 2'b11, MAC_M));
    lookup("R4 mcast from port0", MAC_M, 1'b0, 2'b10, 1'b1, 7);
    lookup("R4 mcast from port1", MAC_M, 1'b1, 2'b01, 1'b1, 7);
  endtask

  task automatic t_types();
    put(7, ent(2'd2, 1'b0, 2'd1, MAC_C));
    put(8, ent(2'd3, 1'b0, 2'd0, MAC_D));
    lookup("R3 vlan-only type misses", MAC_C, 1'b0, 2'b10, 1'b0, N);
    lookup("R3 vlan+addr type hits", MAC_D, 1'b1, 2'b01, 1'b1, 9);
  endtask

  task automatic t_prio();
    put(2, ent(2'd1, 1'b0, 2'd0, MAC_A));
    lookup("R8 lowest index wins", MAC_A, 1'b1, 2'b01, 1'b1, 3);
  endtask

  task automatic t_state();
    wr(8'h24, 32'd2);
    lookup("R7 learning port not flooded", MAC_X, 1'b0, 2'b00, 1'b0, N);
    lookup("R7 learning port not in mcast", MAC_M, 1'b0, 2'b00, 1'b1, 7);
    wr(8'h24, 32'd3);
    wr(8'h20, 32'd1);
    lookup("R7 blocked port not flooded", MAC_X, 1'b1, 2'b00, 1'b0, N);
    wr(8'h20, 32'd3);
  endtask

  task automatic t_backpressure();
    int cnt = 0;
    @(negedge clk);
    lk_valid = 1'b1; lk_dmac = MAC_A; lk_port = 1'b1;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    while (!res_valid && cnt < 200) begin @(negedge clk); cnt++; end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 valid held", {31'd0, res_valid}, 1);
      chk("R10 mask held", {30'd0, res_mask}, 32'b01);
      chk("R10 no accept", {31'd0, lk_ready}, 0);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk("R10 released", {31'd0, res_valid}, 0);
  endtask

  task automatic t_disable();
    wr(8'h00, 32'h0);
    chk("R11 ready low when disabled", {31'd0, lk_ready}, 0);
    wr(8'h00, 32'h8000_0000);
    chk("R11 ready back", {31'd0, lk_ready}, 1);
  endtask

  task automatic t_clear();
    wr(8'h00, 32'hC000_0000);
    reg_addr = 8'h00;
    #0.5;
    chk("R9 clear bit set", {31'd0, reg_rdata[30]}, 1);
    chk("R9 ready low in clear", {31'd0, lk_ready}, 0);
    repeat (N - 1) @(negedge clk);
    #0.5;
    chk("R9 clear bit before end", {31'd0, reg_rdata[30]}, 1);
    @(negedge clk);
    #0.5;
    chk("R9 clear bit self-cleared", {31'd0, reg_rdata[30]}, 0);
    lookup("R9 table empty after clear", MAC_A, 1'b1, 2'b01, 1'b0, N);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_words();
    t_miss();
    t_unicast();
    t_mcast();
    t_types();
    t_prio();
    t_state();
    t_backpressure();
    t_disable();
    t_clear();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule